// File: doc/BRIEF.md
# Multithreaded Fetch Queue with Squash

This block is a circular instruction buffer between the instruction-cache return path and decode, in a front end that fetches for several hardware threads at once. The fetch policy first claims space for a thread with a reserve request. The instruction arrives later through an append request, which uses up one of that thread's claims. Decode removes entries in order from the head with a pull request. Each entry holds an instruction tag and the id of the thread that owns it.

When a thread is redirected, a squash marks its queued entries as dead but leaves them where they are. Dead entries still leave through the head in order. The pull output carries a flag so that decode can drop them. A global squash kills every thread at once. The block keeps counts of reserved, valid and squashed slots, both in total and for each thread, and the fetch policy reads these counts to steer fetch.

Depth and thread count are powers of two. Requests that break a rule are dropped rather than corrupting state. These are: a reserve with no free slot, an append with no reservation, a pull from an empty queue, and a reserve or append during a squash cycle.

Top module: `fetch_queue`

## Requirements
- R1: After synchronous reset all counts are zero and `pull_vld` and `pull_err` are low.
- R2: A reserve raises `tot_rsv` and the thread's reserved count by one when reserved plus valid plus squashed is below DEPTH. Otherwise the reserve is ignored.
- R3: An append whose thread has a reserved count above zero writes its tag at the tail. It moves one count from that thread's reserved field to its valid field, and the totals follow. An append with no reservation is ignored.
- R4: A pull on a non-empty queue returns the head entry one cycle later on `pull_vld`/`pull_tag`/`pull_tid`. Entries leave in append order.
- R5: A pulled entry that was squashed comes out with `pull_sq` high and lowers its thread's squashed count. A live entry comes out with `pull_sq` low and lowers its thread's valid count.
- R6: A per-thread squash (`sq_one`, `sq_tid`) moves every queued valid entry of that thread to squashed and sets that thread's reserved count to zero. It subtracts that reserved count from the total and leaves every other thread unchanged.
- R7: A global squash (`sq_all`, which wins over `sq_one`) marks every queued valid entry squashed and sets every reserved count to zero.
- R8: In a cycle with any squash, reserve and append requests are ignored.
- R9: A pull in the same cycle as a squash sees the head entry's flag as it was before the squash. That entry leaves as it was and is not counted by the squash.
- R10: A pull on an empty queue (valid plus squashed equal to zero) raises `pull_err` for one cycle, keeps `pull_vld` low and changes no count.
- R11: Each total count equals the sum of the matching per-thread counts. Per-thread fields are packed with thread t at bits [t*CW +: CW], where CW = clog2(DEPTH+1).
- R12: Head and tail indices wrap modulo DEPTH, so long mixed traffic keeps FIFO order and correct counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsv_req | input | 1 | Reserve a slot |
| rsv_tid | input | TIDW | Thread of the reserve |
| app_req | input | 1 | Append an instruction |
| app_tid | input | TIDW | Thread of the append |
| app_tag | input | TAG_W | Instruction tag to store |
| pull_req | input | 1 | Remove the head entry |
| sq_all | input | 1 | Squash all threads |
| sq_one | input | 1 | Squash one thread |
| sq_tid | input | TIDW | Thread to squash |
| pull_vld | output | 1 | An entry was pulled last cycle |
| pull_sq | output | 1 | Pulled entry is dead |
| pull_tid | output | TIDW | Thread of pulled entry |
| pull_tag | output | TAG_W | Tag of pulled entry |
| pull_err | output | 1 | Pull on empty queue last cycle |
| tot_rsv | output | CW | Total reserved slots |
| tot_vld | output | CW | Total valid entries |
| tot_sq | output | CW | Total squashed entries |
| thr_rsv | output | THREADS*CW | Per-thread reserved counts |
| thr_vld | output | THREADS*CW | Per-thread valid counts |
| thr_sq | output | THREADS*CW | Per-thread squashed counts |

## Verification
The assertions assume only that reset is held from time zero. They place no limit on request patterns, because the block drops illegal requests itself, so the occupancy bound and the count sums must hold under any input. Thread ids cannot fall out of range, since the thread count is a power of two and every code is a real thread. The stimulus therefore drives unconstrained pseudo-random mixes on a four-entry, two-thread build, with squash made rarer so the queue fills. Directed runs add overfill, empty pull, squash with pull and squash with reserve and append.

// File: rtl/fq_pkg.sv
package fq_pkg;
  typedef struct packed {
    logic live;
    logic dead;
  } fq_flag_t;
endpackage

// File: rtl/fq_entries.sv
module fq_entries
  import fq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int THREADS = 4,
  parameter int TAG_W   = 32,
  localparam int AW     = $clog2(DEPTH),
  localparam int TIDW   = $clog2(THREADS),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_idx,
  input  logic [TIDW-1:0]       wr_tid,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic                  rd_en,
  input  logic [AW-1:0]         rd_idx,
  input  logic                  kill_all,
  input  logic                  kill_one,
  input  logic [TIDW-1:0]       kill_tid,
  output logic                  head_dead,
  output logic [TIDW-1:0]       head_tid,
  output logic [TAG_W-1:0]      rd_tag,
  output logic [DEPTH-1:0]      live_vec,
  output logic [THREADS*CW-1:0] kill_cnt
);
  fq_flag_t          flg   [DEPTH];
  logic [TIDW-1:0]   tid_q [DEPTH];
  logic [TAG_W-1:0]  mem   [DEPTH];
  logic [DEPTH-1:0]  hit;

  assign head_dead = flg[rd_idx].dead;
  assign head_tid  = tid_q[rd_idx];

  // Parallel squash compare; the entry leaving this cycle is excluded.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      hit[i] = flg[i].live && !flg[i].dead &&
               (kill_all || (kill_one && tid_q[i] == kill_tid)) &&
               !(rd_en && rd_idx == AW'(i));
    end
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_cnt
    always_comb begin
      logic [CW-1:0] acc;
      acc = '0;
      for (int i = 0; i < DEPTH; i++)
        acc = acc + CW'(hit[i] && tid_q[i] == TIDW'(t));
      kill_cnt[t*CW +: CW] = acc;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    assign live_vec[i] = flg[i].live;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        flg[i]   <= '0;
        tid_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rd_en && rd_idx == AW'(i)) flg[i] <= '0;
        else if (hit[i])               flg[i].dead <= 1'b1;
        if (wr_en && wr_idx == AW'(i)) begin
          flg[i]   <= '{live: 1'b1, dead: 1'b0};
          tid_q[i] <= wr_tid;
        end
      end
    end
  end

  // Tag store: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= mem[rd_idx];
  end
endmodule

// File: rtl/fq_thread_cnt.sv
module fq_thread_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc_rsv,
  input  logic          use_rsv,
  input  logic          pull_live,
  input  logic          pull_dead,
  input  logic [CW-1:0] kill,
  output logic [CW-1:0] rsv,
  output logic [CW-1:0] vld,
  output logic [CW-1:0] sq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsv <= '0;
      vld <= '0;
      sq  <= '0;
    end else begin
      rsv <= clr ? '0 : rsv + CW'(inc_rsv) - CW'(use_rsv);
      vld <= vld + CW'(use_rsv) - CW'(pull_live) - kill;
      sq  <= sq + kill - CW'(pull_dead);
    end
  end

  a_r6_thread_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (rsv == '0 && vld == '0));
  a_r5_pull_underflow: assert property (@(posedge clk) disable iff (rst)
    (pull_live |-> vld != '0) and (pull_dead |-> sq != '0));
  a_r3_append_credit: assert property (@(posedge clk) disable iff (rst)
    use_rsv |-> rsv != '0);
endmodule

// File: rtl/fetch_queue.sv
module fetch_queue #(
  parameter int DEPTH   = 8,
  parameter int THREADS = 4,
  parameter int TAG_W   = 32,
  localparam int AW     = $clog2(DEPTH),
  localparam int TIDW   = $clog2(THREADS),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rsv_req,
  input  logic [TIDW-1:0]       rsv_tid,
  input  logic                  app_req,
  input  logic [TIDW-1:0]       app_tid,
  input  logic [TAG_W-1:0]      app_tag,
  input  logic                  pull_req,
  input  logic                  sq_all,
  input  logic                  sq_one,
  input  logic [TIDW-1:0]       sq_tid,
  output logic                  pull_vld,
  output logic                  pull_sq,
  output logic [TIDW-1:0]       pull_tid,
  output logic [TAG_W-1:0]      pull_tag,
  output logic                  pull_err,
  output logic [CW-1:0]         tot_rsv,
  output logic [CW-1:0]         tot_vld,
  output logic [CW-1:0]         tot_sq,
  output logic [THREADS*CW-1:0] thr_rsv,
  output logic [THREADS*CW-1:0] thr_vld,
  output logic [THREADS*CW-1:0] thr_sq
);
  localparam int UW = CW + 2;

  logic [AW-1:0]         head, tail;
  logic [CW-1:0]         rsv_a [THREADS];
  logic [CW-1:0]         vld_a [THREADS];
  logic [CW-1:0]         sq_a  [THREADS];
  logic [THREADS*CW-1:0] kill_cnt;
  logic [CW-1:0]         kill_tot;
  logic [DEPTH-1:0]      live_vec;
  logic                  head_dead;
  logic [TIDW-1:0]       head_tid;
  logic [UW-1:0]         used;
  logic                  empty, squash, rsv_ok, app_ok, pull_fire;
  logic                  pull_live_any, pull_dead_any;

  assign used   = UW'(tot_rsv) + UW'(tot_vld) + UW'(tot_sq);
  assign empty  = (tot_vld == '0) && (tot_sq == '0);
  assign squash = sq_all || sq_one;
  assign rsv_ok = rsv_req && !squash && (used < UW'(DEPTH));
  assign app_ok = app_req && !squash && (rsv_a[app_tid] != '0);
  assign pull_fire     = pull_req && !empty;
  assign pull_live_any = pull_fire && !head_dead;
  assign pull_dead_any = pull_fire && head_dead;

  always_comb begin
    kill_tot = '0;
    for (int t = 0; t < THREADS; t++) kill_tot = kill_tot + kill_cnt[t*CW +: CW];
  end

  fq_entries #(.DEPTH(DEPTH), .THREADS(THREADS), .TAG_W(TAG_W)) u_entries (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (app_ok),
    .wr_idx   (tail),
    .wr_tid   (app_tid),
    .wr_tag   (app_tag),
    .rd_en    (pull_fire),
    .rd_idx   (head),
    .kill_all (sq_all),
    .kill_one (sq_one),
    .kill_tid (sq_tid),
    .head_dead(head_dead),
    .head_tid (head_tid),
    .rd_tag   (pull_tag),
    .live_vec (live_vec),
    .kill_cnt (kill_cnt)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    fq_thread_cnt #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .clr      (sq_all || (sq_one && sq_tid == TIDW'(t))),
      .inc_rsv  (rsv_ok && rsv_tid == TIDW'(t)),
      .use_rsv  (app_ok && app_tid == TIDW'(t)),
      .pull_live(pull_live_any && head_tid == TIDW'(t)),
      .pull_dead(pull_dead_any && head_tid == TIDW'(t)),
      .kill     (kill_cnt[t*CW +: CW]),
      .rsv      (rsv_a[t]),
      .vld      (vld_a[t]),
      .sq       (sq_a[t])
    );
    assign thr_rsv[t*CW +: CW] = rsv_a[t];
    assign thr_vld[t*CW +: CW] = vld_a[t];
    assign thr_sq[t*CW +: CW]  = sq_a[t];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head     <= '0;
      tail     <= '0;
      tot_rsv  <= '0;
      tot_vld  <= '0;
      tot_sq   <= '0;
      pull_vld <= 1'b0;
      pull_sq  <= 1'b0;
      pull_tid <= '0;
      pull_err <= 1'b0;
    end else begin
      if (app_ok)    tail <= tail + AW'(1);
      if (pull_fire) head <= head + AW'(1);
      if (sq_all)      tot_rsv <= '0;
      else if (sq_one) tot_rsv <= tot_rsv - rsv_a[sq_tid];
      else             tot_rsv <= tot_rsv + CW'(rsv_ok) - CW'(app_ok);
      tot_vld  <= tot_vld + CW'(app_ok) - CW'(pull_live_any) - kill_tot;
      tot_sq   <= tot_sq + kill_tot - CW'(pull_dead_any);
      pull_vld <= pull_fire;
      pull_sq  <= head_dead;
      pull_tid <= head_tid;
      pull_err <= pull_req && empty;
    end
  end

  logic [UW-1:0] sum_rsv, sum_vld, sum_sq;
  always_comb begin
    sum_rsv = '0;
    sum_vld = '0;
    sum_sq  = '0;
    for (int t = 0; t < THREADS; t++) begin
      sum_rsv = sum_rsv + UW'(rsv_a[t]);
      sum_vld = sum_vld + UW'(vld_a[t]);
      sum_sq  = sum_sq + UW'(sq_a[t]);
    end
  end

  a_r11_total_sums: assert property (@(posedge clk) disable iff (rst)
    sum_rsv == UW'(tot_rsv) && sum_vld == UW'(tot_vld) && sum_sq == UW'(tot_sq));
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    used <= UW'(DEPTH));
  a_r12_live_match: assert property (@(posedge clk) disable iff (rst)
    $countones(live_vec) == int'(tot_vld) + int'(tot_sq));
  a_r10_empty_pull: assert property (@(posedge clk) disable iff (rst)
    (pull_req && empty) |=> (pull_err && !pull_vld));
  a_r7_global_clear: assert property (@(posedge clk) disable iff (rst)
    sq_all |=> (tot_rsv == '0 && tot_vld == '0));
endmodule

// File: tb/fetch_queue_tb.sv
module fetch_queue_tb;
  localparam int CLK_P = 10;
  localparam int D  = 4;
  localparam int T  = 2;
  localparam int TW = 8;
  localparam int IW = $clog2(T);
  localparam int CW = $clog2(D + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic rsv_req = 0, app_req = 0, pull_req = 0, sq_all = 0, sq_one = 0;
  logic [IW-1:0] rsv_tid = '0, app_tid = '0, sq_tid = '0;
  logic [TW-1:0] app_tag = '0;
  logic pull_vld, pull_sq, pull_err;
  logic [IW-1:0] pull_tid;
  logic [TW-1:0] pull_tag;
  logic [CW-1:0] tot_rsv, tot_vld, tot_sq;
  logic [T*CW-1:0] thr_rsv, thr_vld, thr_sq;

  always #(CLK_P/2) clk = ~clk;

  fetch_queue #(.DEPTH(D), .THREADS(T), .TAG_W(TW)) u_dut (
    .clk(clk), .rst(rst), .rsv_req(rsv_req), .rsv_tid(rsv_tid),
    .app_req(app_req), .app_tid(app_tid), .app_tag(app_tag),
    .pull_req(pull_req), .sq_all(sq_all), .sq_one(sq_one), .sq_tid(sq_tid),
    .pull_vld(pull_vld), .pull_sq(pull_sq), .pull_tid(pull_tid),
    .pull_tag(pull_tag), .pull_err(pull_err), .tot_rsv(tot_rsv),
    .tot_vld(tot_vld), .tot_sq(tot_sq), .thr_rsv(thr_rsv),
    .thr_vld(thr_vld), .thr_sq(thr_sq));

  int checks = 0, errors = 0;
  bit done = 0;
  int m_rsv[T], m_vld[T], m_sq[T];
  int q_tag[D], q_tid[D], q_sq[D];
  int mh = 0, mt = 0, mocc = 0;
  int e_pv, e_ps, e_ptid, e_ptag, e_perr;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic step(input bit rv, input int rt, input bit av, input int at,
                      input int atag, input bit pr, input bit sa, input bit so,
                      input int st, input string rq);
    int used;
    bit fire, aok, rok;
    string prq;
    rsv_req = rv; rsv_tid = IW'(rt); app_req = av; app_tid = IW'(at);
    app_tag = TW'(atag); pull_req = pr; sq_all = sa; sq_one = so; sq_tid = IW'(st);
    used = 0;
    for (int t = 0; t < T; t++) used += m_rsv[t] + m_vld[t] + m_sq[t];
    fire = pr && mocc > 0;
    e_perr = pr && mocc == 0;
    e_pv = fire;
    if (fire) begin
      e_ps = q_sq[mh]; e_ptid = q_tid[mh]; e_ptag = q_tag[mh];
    end
    if (sa || so) begin
      for (int k = 0; k < mocc; k++) begin
        int ix;
        ix = (mh + k) % D;
        if (!(fire && k == 0) && !q_sq[ix] && (sa || q_tid[ix] == st)) begin
          q_sq[ix] = 1; m_vld[q_tid[ix]]--; m_sq[q_tid[ix]]++;
        end
      end
      for (int t = 0; t < T; t++) if (sa || t == st) m_rsv[t] = 0;
    end else begin
      aok = av && m_rsv[at] > 0;
      rok = rv && used < D;
      if (rok) m_rsv[rt]++;
      if (aok) begin
        q_tag[mt] = atag; q_tid[mt] = at; q_sq[mt] = 0;
        mt = (mt + 1) % D; mocc++; m_rsv[at]--; m_vld[at]++;
      end
    end
    if (fire) begin
      if (e_ps) m_sq[e_ptid]--; else m_vld[e_ptid]--;
      mh = (mh + 1) % D; mocc--;
    end
    @(posedge clk);
    @(negedge clk);
    prq = (sa || so) ? "R9" : (e_ps ? "R5" : "R4");
    chk(prq, "pull_vld", int'(pull_vld), e_pv);
    chk("R10", "pull_err", int'(pull_err), e_perr);
    if (e_pv) begin
      chk(prq, "pull_sq", int'(pull_sq), e_ps);
      chk(prq, "pull_tid", int'(pull_tid), e_ptid);
      chk(prq, "pull_tag", int'(pull_tag), e_ptag);
    end
    begin
      int sr, sv, ss;
      sr = 0; sv = 0; ss = 0;
      for (int t = 0; t < T; t++) begin
        chk(rq, "thr_rsv", int'(thr_rsv[t*CW +: CW]), m_rsv[t]);
        chk(rq, "thr_vld", int'(thr_vld[t*CW +: CW]), m_vld[t]);
        chk(rq, "thr_sq", int'(thr_sq[t*CW +: CW]), m_sq[t]);
        sr += m_rsv[t]; sv += m_vld[t]; ss += m_sq[t];
      end
      chk("R11", "tot_rsv", int'(tot_rsv), sr);
      chk("R11", "tot_vld", int'(tot_vld), sv);
      chk("R11", "tot_sq", int'(tot_sq), ss);
    end
  endtask

  task automatic idle(input string rq);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    for (int t = 0; t < T; t++) begin m_rsv[t] = 0; m_vld[t] = 0; m_sq[t] = 0; end
    for (int i = 0; i < D; i++) begin q_tag[i] = 0; q_tid[i] = 0; q_sq[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "tot_rsv", int'(tot_rsv), 0);
    chk("R1", "tot_vld", int'(tot_vld), 0);
    chk("R1", "tot_sq", int'(tot_sq), 0);
    chk("R1", "thr_vld", int'(thr_vld), 0);
    chk("R1", "pull_vld", int'(pull_vld), 0);
    chk("R1", "pull_err", int'(pull_err), 0);
    // R2: fill reservations, fifth request must be dropped
    for (int i = 0; i < 5; i++) step(1, i % 2, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R3: thread 0 holds 2, thread 1 holds 2; third append of t0 dropped
    step(0, 0, 1, 0, 8'h11, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 1, 8'h21, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 8'h12, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 0, 8'h13, 0, 0, 0, 0, "R3");
    step(0, 0, 1, 1, 8'h22, 0, 0, 0, 0, "R3");
    // R4: in-order pull
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R4");
    // R9 + R6: squash thread 0 while pulling the thread-1 head
    step(0, 0, 0, 0, 0, 1, 0, 1, 0, "R6");
    // R5: drain squashed and live entries
    for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R5");
    // R10: pull on empty queue
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R10");
    idle("R10");
    // R8: reserve and append in a squash cycle are ignored
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 1, 1, 1, 8'h31, 0, 0, 1, 1, "R8");
    step(1, 0, 1, 0, 8'h32, 0, 1, 0, 0, "R8");
    // R7: global squash with entries of both threads and open reservations
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 1, 1, 0, 8'h41, 0, 0, 0, 0, "R7");
    step(1, 1, 1, 1, 8'h42, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 1, 1, "R7");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R5");
    // R12: long pseudo-random traffic, pointers wrap many times
    lf = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[0], int'(lf[1]), lf[2], int'(lf[3]), int'(lf[11:4]), lf[12] | lf[13],
           lf[19:14] == 6'd0, lf[23:20] == 4'd0, int'(lf[24]), "R12");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule